// File: doc/BRIEF.md
# Stop-Clock Throttling Modulator

This block produces the active-low stop-clock signal that a power-management unit sends to a processor. Software enters a low-power state by reading one of two idle ports, and the block sees each read as a single-cycle strobe. A read of the level-2 port does one of two things, chosen by a throttle-enable bit that is sampled at the moment of the read. With throttling off, the processor clock is stopped outright. With throttling on, the stop-clock output follows a repeating pattern of eight equal slots. A read of the level-3 port holds the output asserted and raises a deep-state flag.

The slot length is a parameter, given in cycles of the block clock. A 3-bit duty code sets how many slots of each period hold the output asserted, and that count is the code minus one. Every state ends on a break input, which is the OR of all enabled interrupt and wake sources. Gating the clock itself and handling it on the processor side belong to other blocks.

Top module: `stpclk_throttle`

## Requirements
- R1: After reset the stop-clock output is high (deasserted), the deep flag is low, and the output stays high while the block is running.
- R2: A level-2 read strobe with throttle-enable 0 drives the output low from the cycle after the strobe, and it stays low until a break.
- R3: A level-2 read strobe with throttle-enable 1 starts a period of 8 slots of SLOT_CYCLES cycles each, beginning in the cycle after the strobe. The output is low in slots 0 to code−2 and high in the remaining slots, so it is low for (code−1)·SLOT_CYCLES cycles of every 8·SLOT_CYCLES.
- R4: While the block is throttling, duty codes 000 (reserved) and 001 keep the output high in every slot.
- R5: A change to the duty code during throttling takes effect only from the next period boundary. Throttle-enable is sampled only when a level-2 read strobe arrives.
- R6: A level-3 read strobe drives the output low and raises the deep flag from the next cycle until a break. When both read strobes arrive in the same cycle, the level-3 read wins.
- R7: A break drives the output high and the deep flag low in the cycle after it is sampled, from any state. A break in the same cycle as a read strobe overrides the read.
- R8: Read strobes that arrive while the block is not running are ignored. A level-3 read during a stop does not raise the deep flag, and a level-2 read during throttling does not restart the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lvl2_rd_i | input | 1 | One-cycle strobe: level-2 idle port was read |
| lvl3_rd_i | input | 1 | One-cycle strobe: level-3 idle port was read |
| thr_en_i | input | 1 | Throttle enable, sampled on a level-2 read |
| duty_code_i | input | DUTY_W (3) | Duty code; asserted slots = code − 1 |
| brk_i | input | 1 | Break event (enabled interrupt or wake) |
| stpclk_n_o | output | 1 | Active-low stop-clock to the processor |
| deep_o | output | 1 | High while in the level-3 state |

## Verification
The assertions take every input to be synchronous to `clk`. They take the read strobes and the break to be pulses of a single cycle, and they allow these pulses to coincide. The slot-advance and code-hold properties also assume that the duty code can move at any cycle, while throttle-enable matters only in a strobe cycle. The stimulus changes every input on the falling clock edge and keeps each strobe and break high for exactly one cycle. It sends simultaneous strobes, and strobes together with a break, only where a scenario checks priority.

// File: rtl/stpclk_pkg.sv
// Package: shared state type for the stop-clock throttling modulator.
// Assumes a single clock domain; states are encoded in two bits.
package stpclk_pkg;
    typedef enum logic [1:0] {
        PS_RUN  = 2'd0,
        PS_STOP = 2'd1,
        PS_THR  = 2'd2,
        PS_DEEP = 2'd3
    } pm_state_e;
endpackage

// File: rtl/stpclk_slot_timer.sv
// Slot timer: divides the clock into slots of SLOT_CYCLES cycles and counts
// slots modulo 2**SLOT_BITS. Counts only while run is high; restart zeroes
// both counters. Assumes SLOT_CYCLES >= 1.
module stpclk_slot_timer #(
    parameter int SLOT_CYCLES = 4,
    parameter int SLOT_BITS   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic                 run,
    output logic [SLOT_BITS-1:0] slot_o,
    output logic                 slot_end_o,
    output logic                 period_end_o
);
    localparam int PRE_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SLOT_CYCLES - 1);

    logic [PRE_W-1:0]     pre_q;
    logic [SLOT_BITS-1:0] slot_q;

    // Flag the last cycle of a slot and of a whole period.
    always_comb begin
        slot_end_o   = run && (pre_q == PRE_LAST);
        period_end_o = slot_end_o && (&slot_q);
    end

    // Advance the prescaler, and the slot index when a slot completes.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre_q  <= '0;
            slot_q <= '0;
        end else if (run) begin
            if (slot_end_o) begin
                pre_q  <= '0;
                slot_q <= slot_q + 1'b1;
            end else begin
                pre_q  <= pre_q + 1'b1;
            end
        end
    end

    assign slot_o = slot_q;
endmodule

// File: rtl/stpclk_duty_cmp.sv
// Duty comparator: requests stop for slot indices below (code - 1).
// Codes 0 and 1 never request stop; purely combinational.
module stpclk_duty_cmp #(
    parameter int SLOT_BITS = 3
) (
    input  logic [SLOT_BITS-1:0] slot_i,
    input  logic [SLOT_BITS-1:0] code_i,
    output logic                 stop_o
);
    // Compare slot+1 against the code in one extra bit to avoid wrap.
    always_comb begin
        stop_o = ({1'b0, slot_i} + 1'b1) < {1'b0, code_i};
    end
endmodule

// File: rtl/stpclk_throttle.sv
// Top: stop-clock throttling modulator. Read strobes on the level-2/level-3
// idle ports move the block out of the running state; a break returns it.
// Assumes all inputs are synchronous to clk and strobes are one cycle wide.
module stpclk_throttle #(
    parameter int SLOT_CYCLES = 4,
    parameter int DUTY_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl2_rd_i,
    input  logic              lvl3_rd_i,
    input  logic              thr_en_i,
    input  logic [DUTY_W-1:0] duty_code_i,
    input  logic              brk_i,
    output logic              stpclk_n_o,
    output logic              deep_o
);
    import stpclk_pkg::*;

    pm_state_e         state_q, state_d;
    logic [DUTY_W-1:0] code_q;
    logic [DUTY_W-1:0] slot;
    logic              slot_end, period_end;
    logic              restart, load_code, cmp_stop, thr_run;

    // Next-state decision; break has priority over every read strobe.
    always_comb begin
        state_d   = state_q;
        restart   = 1'b0;
        load_code = 1'b0;
        if (brk_i) begin
            state_d = PS_RUN;
        end else if (state_q == PS_RUN) begin
            if (lvl3_rd_i) begin
                state_d = PS_DEEP;
            end else if (lvl2_rd_i) begin
                if (thr_en_i) begin
                    state_d   = PS_THR;
                    restart   = 1'b1;
                    load_code = 1'b1;
                end else begin
                    state_d = PS_STOP;
                end
            end
        end
    end

    assign thr_run = (state_q == PS_THR);

    // Hold the power state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_RUN;
        else        state_q <= state_d;
    end

    // Capture the duty code on entry and at each period boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n)                                code_q <= '0;
        else if (load_code || (thr_run && period_end)) code_q <= duty_code_i;
    end

    stpclk_slot_timer #(
        .SLOT_CYCLES (SLOT_CYCLES),
        .SLOT_BITS   (DUTY_W)
    ) timer_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (restart),
        .run          (thr_run),
        .slot_o       (slot),
        .slot_end_o   (slot_end),
        .period_end_o (period_end)
    );

    stpclk_duty_cmp #(
        .SLOT_BITS (DUTY_W)
    ) cmp_i (
        .slot_i (slot),
        .code_i (code_q),
        .stop_o (cmp_stop)
    );

    // Drive the outputs from registered state only.
    always_comb begin
        stpclk_n_o = !((state_q == PS_STOP) || (state_q == PS_DEEP) ||
                       (thr_run && cmp_stop));
        deep_o     = (state_q == PS_DEEP);
    end
endmodule

// File: rtl/stpclk_throttle_chk.sv
// Checker: temporal properties of the stop-clock modulator, bound to the top.
// Assumes synchronous inputs; all properties are disabled during reset.
module stpclk_throttle_chk #(
    parameter int DUTY_W = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  brk_i,
    input logic                  stpclk_n_o,
    input logic                  deep_o,
    input stpclk_pkg::pm_state_e state_q,
    input logic [DUTY_W-1:0]     slot,
    input logic                  slot_end,
    input logic                  period_end,
    input logic [DUTY_W-1:0]     code_q
);
    import stpclk_pkg::*;

    AST_RUN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_RUN) |-> stpclk_n_o); // R1
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_STOP && !brk_i) |=> (state_q == PS_STOP && !stpclk_n_o)); // R2
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_THR && slot_end && !brk_i) |=> (slot == DUTY_W'($past(slot) + 1'b1))); // R3
    AST_LOW_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_THR && code_q <= DUTY_W'(1)) |-> stpclk_n_o); // R4
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_THR && !period_end && !brk_i) |=> $stable(code_q)); // R5
    AST_DEEP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        deep_o |-> !stpclk_n_o); // R6
    AST_BRK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        brk_i |=> (stpclk_n_o && !deep_o)); // R7
    AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PS_RUN && !brk_i) |=> (state_q == $past(state_q))); // R8
endmodule

bind stpclk_throttle stpclk_throttle_chk #(.DUTY_W(DUTY_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .brk_i      (brk_i),
    .stpclk_n_o (stpclk_n_o),
    .deep_o     (deep_o),
    .state_q    (state_q),
    .slot       (slot),
    .slot_end   (slot_end),
    .period_end (period_end),
    .code_q     (code_q)
);

// File: tb/stpclk_throttle_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, inputs driven and outputs sampled
// on the falling edge.
module stpclk_throttle_tb_top;
    localparam int SC  = 4;
    localparam int PER = 8 * SC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lvl2 = 1'b0, lvl3 = 1'b0, thr_en = 1'b0, brk = 1'b0;
    logic [2:0] duty = 3'd0;
    logic       stpclk_n, deep;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    stpclk_throttle #(.SLOT_CYCLES(SC), .DUTY_W(3)) dut_i (
        .clk (clk), .rst_n (rst_n), .lvl2_rd_i (lvl2), .lvl3_rd_i (lvl3),
        .thr_en_i (thr_en), .duty_code_i (duty), .brk_i (brk),
        .stpclk_n_o (stpclk_n), .deep_o (deep)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic do_break(input string req);
        brk = 1'b1; tick(); brk = 1'b0;
        chk({req, " break out high"}, stpclk_n, 1'b1);
        chk({req, " break deep low"}, deep, 1'b0);
    endtask

    // R1: reset state and idle level
    task automatic t_reset();
        rst_n = 1'b0; repeat (3) tick(); rst_n = 1'b1; tick();
        chk("R1 out after reset", stpclk_n, 1'b1);
        chk("R1 deep after reset", deep, 1'b0);
        repeat (5) tick();
        chk("R1 idle high", stpclk_n, 1'b1);
    endtask

    // R2 stop; R8 level-3 read ignored while stopped
    task automatic t_stop();
        thr_en = 1'b0; lvl2 = 1'b1; tick(); lvl2 = 1'b0;
        chk("R2 stop asserted", stpclk_n, 1'b0);
        repeat (40) tick();
        chk("R2 stop held", stpclk_n, 1'b0);
        lvl3 = 1'b1; tick(); lvl3 = 1'b0;
        chk("R8 lvl3 ignored in stop", deep, 1'b0);
        chk("R8 still stopped", stpclk_n, 1'b0);
        do_break("R7 stop");
        repeat (3) tick();
    endtask

    // R3/R4/R5/R8: throttling pattern, per-cycle compare
    task automatic t_throttle(input logic [2:0] code, input int nper,
                              input logic [2:0] newc, input int chg_at,
                              input int rd_at, input string req);
        int low_cnt;
        low_cnt = 0;
        thr_en = 1'b1; duty = code; lvl2 = 1'b1; tick(); lvl2 = 1'b0;
        thr_en = 1'b0;
        for (int i = 0; i < nper * PER; i++) begin
            int p, s, ec;
            logic e;
            p  = i / PER;
            s  = (i % PER) / SC;
            ec = (p == 0 || chg_at < 0) ? int'(code) : int'(newc);
            e  = !((s + 1) < ec);
            if (stpclk_n !== e) begin
                chk(req, stpclk_n, e);
            end
            if (p == 0 && stpclk_n === 1'b0) low_cnt++;
            lvl2 = (i == rd_at);
            if (i == chg_at) duty = newc;
            tick();
        end
        lvl2 = 1'b0;
        chk({req, " first-period low count"}, (low_cnt == ((code > 0) ? (int'(code) - 1) * SC : 0)), 1'b1);
        do_break({req, " R7"});
        repeat (3) tick();
    endtask

    // R6: level-3 entry and priority over simultaneous level-2
    task automatic t_deep();
        lvl3 = 1'b1; tick(); lvl3 = 1'b0;
        chk("R6 deep flag", deep, 1'b1);
        chk("R6 deep out low", stpclk_n, 1'b0);
        repeat (20) tick();
        chk("R6 deep held", deep, 1'b1);
        do_break("R7 deep");
        thr_en = 1'b1; duty = 3'd7; lvl2 = 1'b1; lvl3 = 1'b1; tick();
        lvl2 = 1'b0; lvl3 = 1'b0;
        repeat (10) tick();
        chk("R6 lvl3 wins flag", deep, 1'b1);
        chk("R6 lvl3 wins out", stpclk_n, 1'b0);
        do_break("R7 deep2");
        repeat (2) tick();
    endtask

    // R7: break beats a simultaneous read
    task automatic t_brk_prio();
        thr_en = 1'b0; lvl2 = 1'b1; brk = 1'b1; tick(); lvl2 = 1'b0; brk = 1'b0;
        chk("R7 brk over lvl2", stpclk_n, 1'b1);
        lvl3 = 1'b1; brk = 1'b1; tick(); lvl3 = 1'b0; brk = 1'b0;
        chk("R7 brk over lvl3 flag", deep, 1'b0);
        repeat (5) tick();
        chk("R7 still running", stpclk_n, 1'b1);
    endtask

    initial begin
        t_reset();
        t_stop();
        t_throttle(3'd2, 2, 3'd2, -1, -1, "R3 code2");
        t_throttle(3'd5, 2, 3'd5, -1, -1, "R3 code5");
        t_throttle(3'd7, 2, 3'd7, -1, -1, "R3 code7");
        t_throttle(3'd0, 1, 3'd0, -1, -1, "R4 code0");
        t_throttle(3'd1, 1, 3'd1, -1, -1, "R4 code1");
        t_throttle(3'd3, 2, 3'd6, 5, -1, "R5 duty change");
        t_throttle(3'd4, 2, 3'd4, -1, 13, "R8 lvl2 in throttle");
        t_deep();
        t_brk_prio();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule